// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Thresholds

This block is a first-in first-out buffer of 1024 words by 9 bits that sits between a producer on one clock and a consumer on another. The two clocks may be the same net or fully unrelated. Each side has two enables that must both be high for a transfer. The write side reports full and an active-low almost-full flag. The read side reports empty and almost-empty.

The two almost thresholds are held in offset registers. After reset each offset is 7. Software changes them by holding the first write enable high and the second one low. Each such write-clock edge then stores the data word into the next offset field in a fixed rotation, and no word enters the memory. The read data comes from a register that updates on each accepted read. An output enable forces the data output to zero while it is low, and the stored word is kept.

Top module: `twin_clock_fifo`

## Requirements
- R1: A word is stored on a rising write-clock edge only when `wr_en_a` and `wr_en_b` are both 1 and the buffer is not full. Words are read back in the order they were written.
- R2: A read is accepted on a rising read-clock edge when `rd_en_a` and `rd_en_b` are both 1 and the buffer is not empty. The oldest word then appears on `rd_q` after that same edge and holds until the next accepted read.
- R3: When `wr_en_a` is 1 and `wr_en_b` is 0, a write-clock edge loads `wr_data` into an offset field and writes nothing to the memory. Successive loads go to these fields in turn: almost-empty bits [7:0] from `wr_data[7:0]`, almost-empty bits [9:8] from `wr_data[1:0]`, almost-full bits [7:0], almost-full bits [9:8], and then back to the first field. Only reset returns the rotation to the first field.
- R4: `rd_empty` is 1 when no word is stored. After a write into an empty buffer it falls no later than three read-clock edges later.
- R5: `wr_full` is 1 when 1024 words are stored. A write while full is dropped.
- R6: A read while empty is ignored: the read pointer does not move and `rd_q` holds its value.
- R7: `rd_aempty` is 1 while the stored count is at most the almost-empty offset. The offset is 7 by default.
- R8: `wr_afull_n` is 0 while the free space is at most the almost-full offset. The offset is 7 by default.
- R9: Offsets that have been loaded move both thresholds, including values above 255 that use the upper field.
- R10: While `rd_oe` is 0, `rd_q` is 0. Reads are still accepted, and the registered word shows again once `rd_oe` returns to 1.
- R11: An active-low asynchronous reset empties the buffer. It sets `rd_empty` and `rd_aempty` to 1, `wr_full` to 0 and `wr_afull_n` to 1, and it restores both offsets to 7.
- R12: Data passes intact when the read clock is unrelated to the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable; 0 with wr_en_a=1 selects offset loading |
| wr_data | input | 9 | Write data or offset load value |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_oe | input | 1 | Output enable; 0 forces rd_q to zero |
| rd_q | output | 9 | Registered read data |
| rd_empty | output | 1 | No words stored (read domain) |
| rd_aempty | output | 1 | Stored count at or below the almost-empty offset |
| wr_full | output | 1 | All 1024 locations used (write domain) |
| wr_afull_n | output | 1 | Active low: free space at or below the almost-full offset |

## Verification
The hardest states to reach are the ones near full. The almost-full edge and a write against a full buffer only appear after about a thousand accepted writes. A threshold above 255 also needs both a high-field load and hundreds of words before its edge appears. The stimulus reaches these states with long write loops that check the flags at the exact word counts around each edge. A load sequence that wraps past the fourth field moves the almost-empty threshold to 276. Unrelated clocks are covered by switching the read side to a second clock with a non-integer period ratio while a writer and a reader run at the same time.

// File: rtl/twin_fifo_pkg.sv
// Shared types and helpers for the dual-clock FIFO.
// Assumes pointer widths never exceed 32 bits.
package twin_fifo_pkg;

    // Rotation of offset fields written in load mode
    typedef enum logic [1:0] {
        SLOT_AE_LO = 2'd0,
        SLOT_AE_HI = 2'd1,
        SLOT_AF_LO = 2'd2,
        SLOT_AF_HI = 2'd3
    } ld_slot_e;

    // Binary to reflected Gray code
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/tf_sync.sv
// Multi-stage flip-flop synchronizer for a Gray-coded bus.
// Assumes only one bit of d changes between destination edges.
module tf_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the bus one stage toward the destination domain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else if (s == 0) begin
                chain[s] <= d;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tf_ram.sv
// Simple dual-port storage: write on wclk, registered read on rclk.
// Assumes the controllers never read and write one address in the same cycle.
module tf_ram #(
    parameter int DW = 9,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store an accepted word
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Capture the oldest word on an accepted read
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end
endmodule

// File: rtl/tf_wr_ctrl.sv
// Write-side control. It keeps the write pointer, sets full and almost-full,
// and holds the offset registers that load mode writes.
// Assumes the offsets are loaded while the read side is idle, because the
// almost-empty offset is used in the read domain without synchronization.
module tf_wr_ctrl
    import twin_fifo_pkg::*;
#(
    parameter int DW          = 9,
    parameter int AW          = 10,
    parameter int LO_W        = 8,
    parameter int DEFAULT_GAP = 7
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          en_a,
    input  logic          en_b,
    input  logic [DW-1:0] data,
    input  logic [AW:0]   r_gray_sync,
    output logic          push,
    output logic [AW:0]   ptr_bin,
    output logic [AW:0]   ptr_gray,
    output logic          full,
    output logic          afull_n,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);
    localparam int PTR_W = AW + 1;
    localparam int OFF_W = AW;
    localparam int HI_W  = OFF_W - LO_W;
    localparam int DEPTH = 1 << AW;

    logic [PTR_W-1:0] r_bin_sync;
    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] room;
    logic [PTR_W-1:0] ptr_next;
    logic             load;
    ld_slot_e         slot;
    ld_slot_e         slot_next;

    // Occupancy seen from the write side
    always_comb begin
        r_bin_sync = PTR_W'(gray_to_bin(32'(r_gray_sync)));
        used       = ptr_bin - r_bin_sync;
        room       = PTR_W'(DEPTH) - used;
        full       = (used == PTR_W'(DEPTH));
        afull_n    = !(room <= PTR_W'(af_off));
        push       = en_a & en_b & ~full;
        load       = en_a & ~en_b;
        ptr_next   = ptr_bin + PTR_W'(push);
    end

    // Advance the write pointer and its Gray copy
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
        end else begin
            ptr_bin  <= ptr_next;
            ptr_gray <= PTR_W'(bin_to_gray(32'(ptr_next)));
        end
    end

    // Choose the field after the current one in the load rotation
    always_comb begin
        case (slot)
            SLOT_AE_LO: slot_next = SLOT_AE_HI;
            SLOT_AE_HI: slot_next = SLOT_AF_LO;
            SLOT_AF_LO: slot_next = SLOT_AF_HI;
            default:    slot_next = SLOT_AE_LO;
        endcase
    end

    // Load the selected offset field and rotate
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            slot   <= SLOT_AE_LO;
            ae_off <= OFF_W'(DEFAULT_GAP);
            af_off <= OFF_W'(DEFAULT_GAP);
        end else if (load) begin
            slot <= slot_next;
            case (slot)
                SLOT_AE_LO: ae_off[LO_W-1:0]     <= data[LO_W-1:0];
                SLOT_AE_HI: ae_off[OFF_W-1:LO_W] <= data[HI_W-1:0];
                SLOT_AF_LO: af_off[LO_W-1:0]     <= data[LO_W-1:0];
                default:    af_off[OFF_W-1:LO_W] <= data[HI_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/tf_rd_ctrl.sv
// Read-side control. It keeps the read pointer and sets empty and almost-empty
// from the synchronized write pointer.
// Assumes ae_off changes only while the read side is idle.
module tf_rd_ctrl
    import twin_fifo_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          en_a,
    input  logic          en_b,
    input  logic [AW:0]   w_gray_sync,
    input  logic [AW-1:0] ae_off,
    output logic          pop,
    output logic [AW:0]   ptr_bin,
    output logic [AW:0]   ptr_gray,
    output logic          empty,
    output logic          aempty
);
    localparam int PTR_W = AW + 1;

    logic [PTR_W-1:0] w_bin_sync;
    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] ptr_next;

    // Occupancy seen from the read side
    always_comb begin
        w_bin_sync = PTR_W'(gray_to_bin(32'(w_gray_sync)));
        used       = w_bin_sync - ptr_bin;
        empty      = (used == '0);
        aempty     = (used <= PTR_W'(ae_off));
        pop        = en_a & en_b & ~empty;
        ptr_next   = ptr_bin + PTR_W'(pop);
    end

    // Advance the read pointer and its Gray copy
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
        end else begin
            ptr_bin  <= ptr_next;
            ptr_gray <= PTR_W'(bin_to_gray(32'(ptr_next)));
        end
    end
endmodule

// File: rtl/twin_clock_fifo.sv
// Dual-clock FIFO with two enables per port, programmable almost thresholds
// and a gated registered output.
// Assumes LO_W = DATA_W-1 is below ADDR_W and ADDR_W-LO_W <= DATA_W, so the
// upper offset field fits in the data word.
module twin_clock_fifo #(
    parameter int DATA_W      = 9,
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int DEFAULT_GAP = 7
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic              rd_oe,
    output logic [DATA_W-1:0] rd_q,
    output logic              rd_empty,
    output logic              rd_aempty,
    output logic              wr_full,
    output logic              wr_afull_n
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int LO_W  = DATA_W - 1;

    logic              w_push;
    logic              r_pop;
    logic [PTR_W-1:0]  w_ptr_bin;
    logic [PTR_W-1:0]  w_ptr_gray;
    logic [PTR_W-1:0]  r_ptr_bin;
    logic [PTR_W-1:0]  r_ptr_gray;
    logic [PTR_W-1:0]  w_gray_at_r;
    logic [PTR_W-1:0]  r_gray_at_w;
    logic [ADDR_W-1:0] ae_off;
    logic [ADDR_W-1:0] af_off;
    logic [DATA_W-1:0] ram_q;

    tf_wr_ctrl #(
        .DW(DATA_W), .AW(ADDR_W), .LO_W(LO_W), .DEFAULT_GAP(DEFAULT_GAP)
    ) u_wr (
        .wclk(wclk), .rst_n(rst_n), .en_a(wr_en_a), .en_b(wr_en_b),
        .data(wr_data), .r_gray_sync(r_gray_at_w), .push(w_push),
        .ptr_bin(w_ptr_bin), .ptr_gray(w_ptr_gray), .full(wr_full),
        .afull_n(wr_afull_n), .ae_off(ae_off), .af_off(af_off)
    );

    tf_rd_ctrl #(.AW(ADDR_W)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .en_a(rd_en_a), .en_b(rd_en_b),
        .w_gray_sync(w_gray_at_r), .ae_off(ae_off), .pop(r_pop),
        .ptr_bin(r_ptr_bin), .ptr_gray(r_ptr_gray), .empty(rd_empty),
        .aempty(rd_aempty)
    );

    tf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(w_ptr_gray), .q(w_gray_at_r)
    );

    tf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(r_ptr_gray), .q(r_gray_at_w)
    );

    tf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .we(w_push), .waddr(w_ptr_bin[ADDR_W-1:0]), .wdata(wr_data),
        .re(r_pop), .raddr(r_ptr_bin[ADDR_W-1:0]), .q(ram_q)
    );

    // Gate the registered word with the output enable
    always_comb begin
        rd_q = rd_oe ? ram_q : '0;
    end
endmodule

// File: rtl/twin_clock_fifo_chk.sv
// Property checker for twin_clock_fifo, attached by bind.
// Assumes rst_n is low at time zero.
module twin_clock_fifo_chk #(
    parameter int PTR_W = 11
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             wr_en_a,
    input logic             wr_en_b,
    input logic             rd_en_a,
    input logic             rd_en_b,
    input logic             wr_full,
    input logic             wr_afull_n,
    input logic             rd_empty,
    input logic             rd_aempty,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] rptr
);
    AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
        (wptr == $past(wptr)) || (wptr == $past(wptr) + 1'b1)); // R1
    AST_LOAD_NO_STORE: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en_a && !wr_en_b) |=> $stable(wptr)); // R3
    AST_FULL_DROPS: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_full && wr_en_a && wr_en_b) |=> $stable(wptr)); // R5
    AST_EMPTY_HOLDS: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_empty && rd_en_a && rd_en_b) |=> $stable(rptr)); // R6
    AST_EMPTY_IS_AE: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_empty |-> rd_aempty); // R7
    AST_FULL_IS_AF: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_full |-> !wr_afull_n); // R8

    // Flags while reset is held
    always @(posedge wclk) begin
        if (!rst_n) begin
            AST_RESET_WFLAGS: assert (!wr_full && wr_afull_n); // R11
        end
    end
endmodule

bind twin_clock_fifo twin_clock_fifo_chk #(.PTR_W(ADDR_W + 1)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .wr_full(wr_full), .wr_afull_n(wr_afull_n),
    .rd_empty(rd_empty), .rd_aempty(rd_aempty),
    .wptr(w_ptr_bin), .rptr(r_ptr_bin)
);

// File: tb/sim_twin_clock_fifo.sv
// Self-checking bench: a vector table, then directed corner-case tests.
module sim_twin_clock_fifo;
    logic       clk = 0;
    logic       aclk = 0;
    logic       rsel = 0;
    logic       rst_n = 0;
    logic       wa = 0, wb = 1, ra = 0, rb = 0, oe = 1;
    logic [8:0] din = '0;
    logic [8:0] rd_q;
    logic       rd_empty, rd_aempty, wr_full, wr_afull_n;
    logic       rclk_w;
    int         checks = 0;
    int         fails = 0;
    logic       done = 0;

    always #5 clk = ~clk;
    always #7 aclk = ~aclk;
    assign rclk_w = rsel ? aclk : clk;

    twin_clock_fifo u0 (
        .wclk(clk), .rclk(rclk_w), .rst_n(rst_n),
        .wr_en_a(wa), .wr_en_b(wb), .wr_data(din),
        .rd_en_a(ra), .rd_en_b(rb), .rd_oe(oe),
        .rd_q(rd_q), .rd_empty(rd_empty), .rd_aempty(rd_aempty),
        .wr_full(wr_full), .wr_afull_n(wr_afull_n)
    );

    // op [19:18]: 0 write din, 1 read and expect exp, 2 wait 3 cycles and expect rd_empty==exp[0]
    localparam logic [19:0] VEC [12] = '{
        {2'd2, 9'h000, 9'h001},
        {2'd0, 9'h011, 9'h000},
        {2'd0, 9'h1FF, 9'h000},
        {2'd0, 9'h000, 9'h000},
        {2'd0, 9'h155, 9'h000},
        {2'd2, 9'h000, 9'h000},
        {2'd1, 9'h000, 9'h011},
        {2'd1, 9'h000, 9'h1FF},
        {2'd1, 9'h000, 9'h000},
        {2'd1, 9'h000, 9'h155},
        {2'd2, 9'h000, 9'h001},
        {2'd1, 9'h000, 9'h155}
    };

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 5) & 511);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input logic [8:0] d);
        wa = 1; wb = 1; din = d;
        @(negedge clk);
        wa = 0;
    endtask

    task automatic do_ld(input logic [8:0] d);
        wa = 1; wb = 0; din = d;
        @(negedge clk);
        wa = 0; wb = 1;
    endtask

    task automatic do_rd();
        ra = 1; rb = 1;
        @(negedge clk);
        ra = 0; rb = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle(3);
        rst_n = 1;
        idle(1);
    endtask

    initial begin
        int errs;
        int got;
        idle(3);
        // R11: flags while reset is held
        check("R11 empty in reset", int'(rd_empty), 1);
        check("R11 aempty in reset", int'(rd_aempty), 1);
        check("R11 full in reset", int'(wr_full), 0);
        check("R11 afull_n in reset", int'(wr_afull_n), 1);
        rst_n = 1;
        idle(1);

        // Table walk: R1 order, R2 registered read, R4 empty, R6 read while empty
        foreach (VEC[k]) begin
            case (VEC[k][19:18])
                2'd0: do_wr(VEC[k][17:9]);
                2'd1: begin
                    do_rd();
                    check(k == 11 ? "R6 read while empty" : "R2 read data",
                          int'(rd_q), int'(VEC[k][8:0]));
                end
                default: begin
                    idle(3);
                    check("R4 empty flag", int'(rd_empty), int'(VEC[k][0]));
                end
            endcase
        end

        // R6: a read while empty did not move the pointer
        do_wr(9'h0AB);
        idle(3);
        do_rd();
        check("R6 pointer held", int'(rd_q), 9'h0AB);

        // R7/R8/R5: fill to full with default offsets
        do_reset();
        for (int i = 0; i < 1024; i++) begin
            do_wr(pat(i));
            if (i == 6) begin idle(3); check("R7 aempty at 7", int'(rd_aempty), 1); end
            if (i == 7) begin idle(3); check("R7 aempty at 8", int'(rd_aempty), 0); end
            if (i == 1015) check("R8 afull_n at free 8", int'(wr_afull_n), 1);
            if (i == 1016) check("R8 afull_n at free 7", int'(wr_afull_n), 0);
            if (i == 1022) check("R5 full at 1023", int'(wr_full), 0);
            if (i == 1023) check("R5 full at 1024", int'(wr_full), 1);
        end
        do_wr(9'h1AA);
        idle(3);
        errs = 0;
        for (int i = 0; i < 1024; i++) begin
            do_rd();
            if (rd_q !== pat(i)) errs++;
        end
        check("R5 R1 full drain mismatches", errs, 0);
        check("R5 dropped write absent", int'(rd_empty), 1);
        idle(3);
        check("R5 full clears", int'(wr_full), 0);

        // R11: reset mid-use restores pointers and default offsets
        do_wr(9'h033);
        do_wr(9'h044);
        do_reset();
        check("R11 empty after reset", int'(rd_empty), 1);
        for (int i = 0; i < 7; i++) do_wr(pat(i + 50));
        idle(3);
        check("R11 default ae at 7", int'(rd_aempty), 1);
        do_wr(pat(57));
        idle(3);
        check("R11 default ae at 8", int'(rd_aempty), 0);
        do_rd();
        check("R11 first word after reset", int'(rd_q), int'(pat(50)));

        // R3/R9: load rotation with wrap: ae = 256+20 = 276, af = 100
        do_reset();
        do_ld(9'd4);
        do_ld(9'd1);
        do_ld(9'd100);
        do_ld(9'd0);
        do_ld(9'd20);
        idle(3);
        check("R3 loads store nothing", int'(rd_empty), 1);
        for (int i = 0; i < 924; i++) begin
            do_wr(pat(i));
            if (i == 275) begin idle(3); check("R9 R3 aempty at 276", int'(rd_aempty), 1); end
            if (i == 276) begin idle(3); check("R9 R3 aempty at 277", int'(rd_aempty), 0); end
            if (i == 922) check("R9 afull_n at 923", int'(wr_afull_n), 1);
            if (i == 923) check("R9 afull_n at 924", int'(wr_afull_n), 0);
        end
        idle(3);
        do_rd();
        check("R3 first word after loads", int'(rd_q), int'(pat(0)));
        idle(3);
        check("R9 afull_n after read", int'(wr_afull_n), 1);

        // R10: output enable gates rd_q, reads still accepted
        oe = 0;
        idle(1);
        check("R10 oe low gives zero", int'(rd_q), 0);
        do_rd();
        check("R10 zero during read", int'(rd_q), 0);
        oe = 1;
        idle(1);
        check("R10 word after oe high", int'(rd_q), int'(pat(1)));

        // R12: unrelated read clock, writer and reader concurrent
        rst_n = 0;
        rsel = 1;
        idle(3);
        rst_n = 1;
        idle(1);
        errs = 0;
        got = 0;
        fork
            begin
                for (int i = 0; i < 60; i++) do_wr(pat(i + 300));
            end
            begin
                while (got < 60) begin
                    @(negedge aclk);
                    if (!rd_empty) begin
                        ra = 1; rb = 1;
                        @(negedge aclk);
                        ra = 0; rb = 0;
                        if (rd_q !== pat(got + 300)) errs++;
                        got++;
                    end
                end
            end
        join
        check("R12 async transfer mismatches", errs, 0);
        check("R12 empty after async drain", int'(rd_empty), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule